// File: doc/BRIEF.md
# ECC Correction Strength Selector

This unit picks an error-correction strength level for a NAND page geometry. When it sees a start pulse, it captures four inputs: the page data size, the out-of-band (spare) area size, and an optional requested correction. The requested correction is given as a step size and a per-step bit strength. Correction always works on fixed 1024-byte chunks. The unit therefore counts the chunks in a page and turns the request into a per-chunk need.

The unit chooses the weakest supported level that still meets that need. If no request is given, it starts from the strongest level. It then steps down one level at a time until the spare bytes that the level consumes, over all chunks, fit in the out-of-band area. When it finishes, it pulses a done output once. It reports the chosen level, the bit strength, the chunk count and the out-of-band bytes per chunk, or it raises an error.

All divisions share one serial shift-subtract divider. A selection therefore takes a few dozen cycles. The results stay on the outputs until the next selection completes.

Top module: `ecc_strength_sel`

## Requirements
- R1: Levels 0, 1, 2, 3 correct 4, 8, 40 and 48 bits per chunk and use 32, 32, 96 and 96 spare bytes per chunk; on success `strength` is the bit count of the reported `level`.
- R2: On success `steps` equals the page size divided by 1024 (truncated), and `oob_per_step` equals the out-of-band size divided by `steps` (truncated).
- R3: An out-of-band size below 64 bytes, or a page smaller than 1024 bytes, ends the selection with `error` high and `level`, `strength`, `steps` and `oob_per_step` all zero.
- R4: With a nonzero requested step and strength, the total is (page / requested step) × requested strength and the need is total / steps (both truncated). The search starts at the smallest level whose bit count is at least the need, or at level 3 if none is.
- R5: A requested step or strength of zero, or a computed total of zero, starts the search at level 3.
- R6: From its starting level the search lowers the level until spare bytes × steps ≤ out-of-band size. If even level 0 does not fit, the result is an error, reported as in R3.
- R7: Each accepted start produces exactly one `done` pulse of one cycle. The outputs hold their values until the next completion.
- R8: A start pulse that arrives while a selection is in progress is ignored: it changes neither the result nor the number of done pulses.
- R9: After reset `done`, `error`, `level`, `strength`, `steps` and `oob_per_step` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a selection; the inputs are captured in this cycle |
| page_bytes | input | PAGE_W | Page data size in bytes |
| oob_bytes | input | OOB_W | Out-of-band area size in bytes |
| req_step | input | STEP_W | Requested step size; zero means no request |
| req_strength | input | STR_W | Requested bits per step; zero means no request |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Geometry cannot be served |
| level | output | 2 | Chosen strength level |
| strength | output | 6 | Correctable bits per chunk |
| steps | output | PAGE_W-10 | Number of 1024-byte chunks |
| oob_per_step | output | OOB_W | Out-of-band bytes per chunk |

## Verification
The assertions rely on the values captured at an accepted start and never on the live inputs. They also rely on the divider seeing a nonzero divisor, which the early checks for a small page or a small out-of-band area guarantee. Because the captured values are all that matter, the stimulus can change the inputs freely while a selection is running. The busy case relies on exactly this: a second start arrives with a different geometry, and the bench checks that only the first geometry's result appears, with a single done pulse. All stimulus keeps the page and request values inside their port widths, so the bench's integer model never sees truncation the design would not see.

// File: rtl/ecc_strength_sel.sv
module ecc_strength_sel #(
  parameter int PAGE_W   = 16,
  parameter int OOB_W    = 12,
  parameter int STEP_W   = 16,
  parameter int STR_W    = 8,
  parameter int CHUNK_LG = 10,
  parameter int MIN_OOB  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] page_bytes,
  input  logic [OOB_W-1:0]  oob_bytes,
  input  logic [STEP_W-1:0] req_step,
  input  logic [STR_W-1:0]  req_strength,
  output logic              done,
  output logic              error,
  output logic [1:0]        level,
  output logic [5:0]        strength,
  output logic [PAGE_W-CHUNK_LG-1:0] steps,
  output logic [OOB_W-1:0]  oob_per_step
);
  localparam int SW = PAGE_W - CHUNK_LG;
  localparam int DW = PAGE_W + STR_W;
  localparam int CW = $clog2(DW + 1);

  typedef enum logic [1:0] {IDLE, DIV, DOWN} st_t;

  st_t             st;
  logic [1:0]      ph;
  logic [CW-1:0]   cnt;
  logic [DW:0]     rem_q, rem_sh, rem_nx;
  logic [DW-1:0]   quo_q, quo_nx, den_q;
  logic [OOB_W-1:0] oob_q, per_q;
  logic [SW-1:0]   steps_q;
  logic [STR_W-1:0] str_q;
  logic            zero_q;
  logic [1:0]      idx_q;

  wire [SW-1:0] steps_in = SW'(page_bytes >> CHUNK_LG);
  wire          has_req  = (req_step != '0) && (req_strength != '0);
  wire [DW-1:0] product  = DW'(quo_q[PAGE_W-1:0]) * DW'(str_q);
  wire [31:0]   sp_need  = 32'(steps_q) * (idx_q[1] ? 32'd96 : 32'd32);
  wire          fits     = sp_need <= 32'(oob_q);

  function automatic logic [5:0] bits_of(input logic [1:0] i);
    case (i)
      2'd0:    return 6'd4;
      2'd1:    return 6'd8;
      2'd2:    return 6'd40;
      default: return 6'd48;
    endcase
  endfunction

  function automatic logic [1:0] round_up(input logic [DW-1:0] need);
    if (need <= DW'(4))       return 2'd0;
    else if (need <= DW'(8))  return 2'd1;
    else if (need <= DW'(40)) return 2'd2;
    else                      return 2'd3;
  endfunction

  always_comb begin
    rem_sh = {rem_q[DW-1:0], quo_q[DW-1]};
    if (rem_sh >= {1'b0, den_q}) begin
      rem_nx = rem_sh - {1'b0, den_q};
      quo_nx = {quo_q[DW-2:0], 1'b1};
    end else begin
      rem_nx = rem_sh;
      quo_nx = {quo_q[DW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; ph <= '0; cnt <= '0;
      rem_q <= '0; quo_q <= '0; den_q <= '0;
      oob_q <= '0; per_q <= '0; steps_q <= '0; str_q <= '0;
      zero_q <= 1'b0; idx_q <= '0;
      done <= 1'b0; error <= 1'b0; level <= '0; strength <= '0;
      steps <= '0; oob_per_step <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          oob_q   <= oob_bytes;
          steps_q <= steps_in;
          str_q   <= req_strength;
          rem_q   <= '0;
          cnt     <= CW'(DW);
          if (oob_bytes < OOB_W'(MIN_OOB) || steps_in == '0) begin
            done <= 1'b1; error <= 1'b1; level <= '0; strength <= '0;
            steps <= '0; oob_per_step <= '0;
          end else if (has_req) begin
            quo_q <= DW'(page_bytes);
            den_q <= DW'(req_step);
            ph    <= 2'd0;
            st    <= DIV;
          end else begin
            idx_q <= 2'd3;
            quo_q <= DW'(oob_bytes);
            den_q <= DW'(steps_in);
            ph    <= 2'd2;
            st    <= DIV;
          end
        end
        DIV: if (cnt != '0) begin
          rem_q <= rem_nx;
          quo_q <= quo_nx;
          cnt   <= cnt - 1'b1;
        end else begin
          rem_q <= '0;
          cnt   <= CW'(DW);
          den_q <= DW'(steps_q);
          case (ph)
            2'd0: begin
              zero_q <= (product == '0);
              quo_q  <= product;
              ph     <= 2'd1;
            end
            2'd1: begin
              idx_q <= zero_q ? 2'd3 : round_up(quo_q);
              quo_q <= DW'(oob_q);
              ph    <= 2'd2;
            end
            default: begin
              per_q <= OOB_W'(quo_q);
              st    <= DOWN;
            end
          endcase
        end
        DOWN: if (fits) begin
          done <= 1'b1; error <= 1'b0; level <= idx_q;
          strength <= bits_of(idx_q);
          steps <= steps_q; oob_per_step <= per_q;
          st <= IDLE;
        end else if (idx_q == 2'd0) begin
          done <= 1'b1; error <= 1'b1; level <= '0; strength <= '0;
          steps <= '0; oob_per_step <= '0;
          st <= IDLE;
        end else begin
          idx_q <= idx_q - 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> st == IDLE);

  p_error_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && error) |-> (level == 2'd0 && strength == 6'd0 && steps == '0 && oob_per_step == '0));

  p_fit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error) |-> 32'(steps) * (level[1] ? 32'd96 : 32'd32) <= 32'(oob_q));

  p_per_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error) |-> 32'(steps) * 32'(oob_per_step) <= 32'(oob_q));

  p_table_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error) |-> (strength == 6'd4 || strength == 6'd8 || strength == 6'd40 || strength == 6'd48));
endmodule

// File: tb/ecc_strength_sel_bench.sv
module ecc_strength_sel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] page_bytes = '0;
  logic [11:0] oob_bytes = '0;
  logic [15:0] req_step = '0;
  logic [7:0]  req_strength = '0;
  logic        done, error;
  logic [1:0]  level;
  logic [5:0]  strength;
  logic [5:0]  steps;
  logic [11:0] oob_per_step;

  int n_tests = 0;
  int n_fail  = 0;
  int n_done  = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) if (done) n_done++;

  ecc_strength_sel u_ecc_strength_sel (
    .clk(clk), .rst_n(rst_n), .start(start), .page_bytes(page_bytes),
    .oob_bytes(oob_bytes), .req_step(req_step), .req_strength(req_strength),
    .done(done), .error(error), .level(level), .strength(strength),
    .steps(steps), .oob_per_step(oob_per_step));

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model(input int page, oob, stp, str,
                                output int e_err, e_lvl, e_str, e_steps, e_per);
    int bits[4]  = '{4, 8, 40, 48};
    int spare[4] = '{32, 32, 96, 96};
    int n, idx, total, need;
    n = page / 1024;
    e_err = 1; e_lvl = 0; e_str = 0; e_steps = 0; e_per = 0;
    if (oob < 64 || n == 0) return;
    idx = 3;
    if (stp != 0 && str != 0) begin
      total = (page / stp) * str;
      if (total != 0) begin
        need = total / n;
        idx = 3;
        for (int i = 3; i >= 0; i--) if (bits[i] >= need) idx = i;
      end
    end
    while (idx >= 0 && spare[idx] * n > oob) idx--;
    if (idx < 0) return;
    e_err = 0; e_lvl = idx; e_str = bits[idx]; e_steps = n; e_per = oob / n;
  endfunction

  task automatic pulse(input int page, oob, stp, str);
    @(negedge clk);
    page_bytes = 16'(page); oob_bytes = 12'(oob);
    req_step = 16'(stp); req_strength = 8'(str);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 500; i++) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    check({req, " done seen"}, int'(ok), 1);
  endtask

  task automatic compare(input string req, input int page, oob, stp, str);
    int e_err, e_lvl, e_str, e_steps, e_per;
    model(page, oob, stp, str, e_err, e_lvl, e_str, e_steps, e_per);
    check({req, " error"}, int'(error), e_err);
    check({req, " level"}, int'(level), e_lvl);
    check({req, " strength"}, int'(strength), e_str);
    check({req, " steps"}, int'(steps), e_steps);
    check({req, " oob_per_step"}, int'(oob_per_step), e_per);
  endtask

  task automatic run_case(input string req, input int page, oob, stp, str);
    bit ok;
    int d0;
    d0 = n_done;
    pulse(page, oob, stp, str);
    wait_done(req, ok);
    compare(req, page, oob, stp, str);
    @(negedge clk);
    check({req, " R7 single pulse"}, int'(done), 0);
    repeat (3) @(negedge clk);
    compare({req, " R7 held"}, page, oob, stp, str);
    check({req, " R7 pulse count"}, n_done - d0, 1);
  endtask

  task automatic t_reset;
    check("R9 done", int'(done), 0);
    check("R9 error", int'(error), 0);
    check("R9 level", int'(level), 0);
    check("R9 strength", int'(strength), 0);
    check("R9 steps", int'(steps), 0);
    check("R9 oob_per_step", int'(oob_per_step), 0);
  endtask

  task automatic t_requested;
    run_case("R4 need16 R1", 2048, 224, 512, 8);
    run_case("R4 need16 stepdown R6", 2048, 64, 512, 8);
    run_case("R4 need4", 4096, 256, 1024, 4);
    run_case("R4 need6", 2048, 128, 512, 3);
    run_case("R4 clamp", 2048, 224, 512, 60);
  endtask

  task automatic t_no_request;
    run_case("R5 none", 2048, 224, 0, 0);
    run_case("R5 zero strength", 4096, 256, 512, 0);
    run_case("R5 zero step", 4096, 512, 0, 8);
    run_case("R5 zero total", 4096, 256, 8192, 8);
    run_case("R2 per-step trunc", 2048, 200, 0, 0);
    run_case("R2 large page", 16384, 1600, 0, 0);
  endtask

  task automatic t_errors;
    run_case("R3 small oob", 2048, 63, 0, 0);
    run_case("R3 small page", 512, 128, 0, 0);
    run_case("R6 no fit", 8192, 64, 0, 0);
    run_case("R6 boundary fit", 8192, 256, 1024, 4);
  endtask

  task automatic t_busy;
    bit ok;
    int d0;
    d0 = n_done;
    pulse(2048, 224, 0, 0);
    repeat (3) @(negedge clk);
    page_bytes = 16'd4096; oob_bytes = 12'd128; req_step = 16'd512; req_strength = 8'd4;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R8 busy", ok);
    compare("R8 busy", 2048, 224, 0, 0);
    repeat (120) @(negedge clk);
    check("R8 busy pulse count", n_done - d0, 1);
    compare("R8 busy held", 2048, 224, 0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_requested();
        t_no_request();
        t_errors();
        t_busy();
      end
      begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule